// File: doc/BRIEF.md
# Multi-bank flash command sequencer

This block watches a parallel asynchronous memory bus (write strobe, output-enable and one enable strobe per bank) and decodes the protected multi-cycle command sequences that software writes to a multi-bank non-volatile memory. The memory has two flash banks and one EEPROM-style bank. The bus strobes are synchronised to a system clock and oversampled. Each write cycle takes its address when the cycle opens and its data when it closes. That address/data pair is then matched against the next expected step of the sequence.

A sequence ends in one of two ways. If it completes, the block raises a single-cycle request tagged with the target bank, the operation type and the address and data of the final cycle. A separate operation timer consumes that request and reports back, per bank, whether the bank is busy. A write cycle that does not fit the sequence drops the decoder back to idle. Read cycles, and write-strobe-high pauses, leave the decoder untouched, so software can read another bank in the middle of a sequence. The unlock addresses, unlock data and command codes are parameters.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rst_ni` is low and after its release with no bus activity, `req_valid_o` stays 0.
- R2: Word program, on any bank. Four write cycles issue exactly one request with op code 1: (U0A, U0D), (U1A, U1D), (U0A, CP), then any target pair. The defaults are U0A=16'h2AA5, U0D=16'h00C3, U1A=16'h1D5A, U1D=16'h003C and CP=16'h00A1.
- R3: Word write uses the same three-cycle prefix with command CW=16'h00A7 and issues op code 2. It is accepted only on the EEPROM-style bank (bank code 2, enable bit 2). On a flash bank (codes 0 and 1, enable bits 0 and 1) the command cycle aborts the sequence.
- R4: Erase needs all six cycles: (U0A, U0D), (U1A, U1D), (U0A, CE=16'h00E0), (U0A, U0D), (U1A, U1D), and then a final cycle. The final cycle selects the operation. Data CB=16'h00E1 at address U0A gives a bank erase (op 5). Data CS=16'h00E2 gives a sector erase (op 3). Data CK=16'h00E3 gives a block erase (op 4) and is valid on flash banks only. No request is issued before the sixth cycle.
- R5: A write cycle whose address or data differs from the expected step aborts the sequence. The rest of the broken sequence then issues nothing, and a fresh sequence is decoded normally.
- R6: Once a sequence has started, a write cycle to a different bank aborts it.
- R7: Read cycles (output-enable low, write strobe high) to other banks between steps neither advance nor abort the sequence.
- R8: The address of a write cycle is taken when the cycle opens (write strobe and bank enable both low). The data is taken when it closes. A request carries the address and data of the final cycle.
- R9: A cycle framed by the bank enable while the write strobe is held low is decoded exactly like a write-strobe-framed cycle.
- R10: A strobe pulse with output-enable held low throughout is not a write cycle. The sequence neither advances nor aborts.
- R11: A first cycle addressed to a bank whose `busy_i` bit is 1 is rejected, so that sequence issues no request. Other banks are unaffected.
- R12: `req_valid_o` is high for exactly one clock per completed sequence. `req_bank_o` is 0 to 2, and `req_op_o` is 1 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_ni | input | 1 | Bus write strobe, active low |
| oe_ni | input | 1 | Bus output enable, active low |
| be_ni | input | NUM_BANKS | Bank enables, active low; bit 2 is the EEPROM-style bank |
| addr_i | input | AW | Bus address |
| data_i | input | DW | Bus write data |
| busy_i | input | NUM_BANKS | Per-bank busy flags from the operation timer |
| req_valid_o | output | 1 | One-cycle operation request |
| req_bank_o | output | BW | Target bank code |
| req_op_o | output | 3 | Operation: 1 program, 2 write, 3 sector erase, 4 block erase, 5 bank erase |
| req_addr_o | output | AW | Address of the final cycle |
| req_data_o | output | DW | Data of the final cycle |

## Verification
The assertions check several properties on every clock:
- requests are single-cycle pulses with legal bank and op codes;
- a word write never targets a flash bank, and a block erase never targets the EEPROM-style bank;
- an erase request only follows the sixth step;
- a cross-bank write or a busy bank returns the step counter to idle.

The bench scenarios are needed for the behaviours that depend on bus timing and on history across cycles: sampling the address on cycle open and the data on cycle close, pausing with interleaved reads, ignoring cycles with output-enable low, enable-framed cycles, and recovery after an abort.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_WRITE = 3'd2,
    OP_SECT  = 3'd3,
    OP_BLK   = 3'd4,
    OP_BANK  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_PROG,
    KIND_WRITE,
    KIND_ERASE
  } kind_e;

  localparam int unsigned N_STEPS = 6;

endpackage

// File: rtl/fseq_strobe_sync.sv
module fseq_strobe_sync #(
  parameter int unsigned AW          = 16,
  parameter int unsigned DW          = 16,
  parameter int unsigned NB          = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BW         = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [NB-1:0] be_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          cyc_end_o,
  output logic [BW-1:0] cyc_bank_o,
  output logic [AW-1:0] cyc_addr_o,
  output logic [DW-1:0] cyc_data_o
);

  localparam int unsigned CW = NB + 2;

  logic [CW-1:0] ctl_raw;
  logic [CW-1:0] stage_q [SYNC_STAGES];
  logic [CW-1:0] ctl_s;
  logic          we_s, oe_s;
  logic [NB-1:0] be_s;
  logic          act, act_q;
  logic [BW-1:0] bank_idx, bank_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign ctl_raw = {we_ni, oe_ni, be_ni};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '1;
        else         stage_q[g] <= ctl_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '1;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign ctl_s = stage_q[SYNC_STAGES-1];
  assign we_s  = ctl_s[CW-1];
  assign oe_s  = ctl_s[CW-2];
  assign be_s  = ctl_s[NB-1:0];

  // write cycle: strobe low, output enable high, exactly one bank enabled
  assign act = !we_s && oe_s && $onehot(~be_s);

  always_comb begin
    bank_idx = '0;
    for (int i = 0; i < NB; i++) begin
      if (!be_s[i]) bank_idx = BW'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      bank_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) begin
        addr_q <= addr_i;
        bank_q <= bank_idx;
      end
      if (act) data_q <= data_i;
    end
  end

  // close only on a strobe release; a cycle cut by output enable is dropped
  assign cyc_end_o  = act_q && !act && oe_s;
  assign cyc_bank_o = bank_q;
  assign cyc_addr_o = addr_q;
  assign cyc_data_o = data_q;

  a_r8_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && act_q) |=> $stable(addr_q))
    else $error("address changed inside a write cycle");

endmodule

// File: rtl/fseq_step_fsm.sv
module fseq_step_fsm
  import fseq_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 16,
  parameter int unsigned NB         = 3,
  parameter logic [AW-1:0] U0_ADDR  = 16'h2AA5,
  parameter logic [DW-1:0] U0_DATA  = 16'h00C3,
  parameter logic [AW-1:0] U1_ADDR  = 16'h1D5A,
  parameter logic [DW-1:0] U1_DATA  = 16'h003C,
  parameter logic [DW-1:0] CMD_PROG = 16'h00A1,
  parameter logic [DW-1:0] CMD_WR   = 16'h00A7,
  parameter logic [DW-1:0] CMD_ERS  = 16'h00E0,
  parameter logic [DW-1:0] CMD_BANK = 16'h00E1,
  parameter logic [DW-1:0] CMD_SECT = 16'h00E2,
  parameter logic [DW-1:0] CMD_BLK  = 16'h00E3,
  localparam int unsigned BW        = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cyc_end_i,
  input  logic [BW-1:0] cyc_bank_i,
  input  logic [AW-1:0] cyc_addr_i,
  input  logic [DW-1:0] cyc_data_i,
  input  logic [NB-1:0] busy_i,
  output logic          req_valid_o,
  output logic [BW-1:0] req_bank_o,
  output op_e           req_op_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_data_o
);

  localparam int unsigned SW      = $clog2(N_STEPS);
  localparam logic [SW-1:0] ST_U0 = SW'(0);
  localparam logic [SW-1:0] ST_U1 = SW'(1);
  localparam logic [SW-1:0] ST_CM = SW'(2);
  localparam logic [SW-1:0] ST_S3 = SW'(3);
  localparam logic [SW-1:0] ST_S4 = SW'(4);
  localparam logic [SW-1:0] ST_S5 = SW'(5);
  localparam logic [BW-1:0] EE_BANK = BW'(NB - 1);

  logic [SW-1:0] step_q, step_n;
  kind_e         kind_q, kind_n;
  logic [BW-1:0] lock_q, lock_n;
  op_e           op_n;
  logic          hit_u0, hit_u1, at_u0, is_ee, bank_busy;

  assign at_u0     = (cyc_addr_i == U0_ADDR);
  assign hit_u0    = at_u0 && (cyc_data_i == U0_DATA);
  assign hit_u1    = (cyc_addr_i == U1_ADDR) && (cyc_data_i == U1_DATA);
  assign is_ee     = (cyc_bank_i == EE_BANK);
  assign bank_busy = busy_i[cyc_bank_i];

  always_comb begin
    step_n = step_q;
    kind_n = kind_q;
    lock_n = lock_q;
    op_n   = OP_NONE;
    if (cyc_end_i) begin
      step_n = ST_U0;
      kind_n = KIND_NONE;
      if (step_q == ST_U0) begin
        if (hit_u0 && !bank_busy) begin
          step_n = ST_U1;
          lock_n = cyc_bank_i;
        end
      end else if (cyc_bank_i == lock_q) begin
        unique case (step_q)
          ST_U1: if (hit_u1) step_n = ST_CM;
          ST_CM: begin
            if (at_u0 && cyc_data_i == CMD_PROG) begin
              step_n = ST_S3; kind_n = KIND_PROG;
            end else if (at_u0 && cyc_data_i == CMD_WR && is_ee) begin
              step_n = ST_S3; kind_n = KIND_WRITE;
            end else if (at_u0 && cyc_data_i == CMD_ERS) begin
              step_n = ST_S3; kind_n = KIND_ERASE;
            end
          end
          ST_S3: begin
            unique case (kind_q)
              KIND_PROG:  op_n = OP_PROG;
              KIND_WRITE: op_n = OP_WRITE;
              KIND_ERASE: if (hit_u0) begin
                step_n = ST_S4; kind_n = KIND_ERASE;
              end
              default: ;
            endcase
          end
          ST_S4: if (hit_u1) begin
            step_n = ST_S5; kind_n = KIND_ERASE;
          end
          ST_S5: begin
            if (at_u0 && cyc_data_i == CMD_BANK)       op_n = OP_BANK;
            else if (cyc_data_i == CMD_SECT)           op_n = OP_SECT;
            else if (cyc_data_i == CMD_BLK && !is_ee)  op_n = OP_BLK;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q      <= ST_U0;
      kind_q      <= KIND_NONE;
      lock_q      <= '0;
      req_valid_o <= 1'b0;
      req_bank_o  <= '0;
      req_op_o    <= OP_NONE;
      req_addr_o  <= '0;
      req_data_o  <= '0;
    end else begin
      step_q      <= step_n;
      kind_q      <= kind_n;
      lock_q      <= lock_n;
      req_valid_o <= (op_n != OP_NONE);
      if (op_n != OP_NONE) begin
        req_bank_o <= lock_q;
        req_op_o   <= op_n;
        req_addr_o <= cyc_addr_i;
        req_data_o <= cyc_data_i;
      end
    end
  end

  a_r6_cross_bank_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_end_i && step_q != ST_U0 && cyc_bank_i != lock_q) |=> (step_q == ST_U0 && !req_valid_o))
    else $error("cross-bank write did not abort");

  a_r11_busy_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_end_i && step_q == ST_U0 && busy_i[cyc_bank_i]) |=> (step_q == ST_U0))
    else $error("busy bank accepted a new sequence");

  a_r4_erase_after_six: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && (req_op_o == OP_SECT || req_op_o == OP_BLK || req_op_o == OP_BANK))
      |-> ($past(step_q) == ST_S5))
    else $error("erase issued before the sixth cycle");

  a_r5_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(step_q) < int'(N_STEPS))
    else $error("step counter out of range");

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned DW          = 16,
  parameter int unsigned NUM_BANKS   = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [AW-1:0] U0_ADDR   = 16'h2AA5,
  parameter logic [DW-1:0] U0_DATA   = 16'h00C3,
  parameter logic [AW-1:0] U1_ADDR   = 16'h1D5A,
  parameter logic [DW-1:0] U1_DATA   = 16'h003C,
  parameter logic [DW-1:0] CMD_PROG  = 16'h00A1,
  parameter logic [DW-1:0] CMD_WR    = 16'h00A7,
  parameter logic [DW-1:0] CMD_ERS   = 16'h00E0,
  parameter logic [DW-1:0] CMD_BANK  = 16'h00E1,
  parameter logic [DW-1:0] CMD_SECT  = 16'h00E2,
  parameter logic [DW-1:0] CMD_BLK   = 16'h00E3,
  localparam int unsigned BW         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_ni,
  input  logic                 oe_ni,
  input  logic [NUM_BANKS-1:0] be_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        data_i,
  input  logic [NUM_BANKS-1:0] busy_i,
  output logic                 req_valid_o,
  output logic [BW-1:0]        req_bank_o,
  output logic [2:0]           req_op_o,
  output logic [AW-1:0]        req_addr_o,
  output logic [DW-1:0]        req_data_o
);

  localparam logic [BW-1:0] EE_BANK = BW'(NUM_BANKS - 1);

  logic          cyc_end;
  logic [BW-1:0] cyc_bank;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data;
  op_e           req_op;

  fseq_strobe_sync #(
    .AW(AW), .DW(DW), .NB(NUM_BANKS), .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_ni      (we_ni),
    .oe_ni      (oe_ni),
    .be_ni      (be_ni),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .cyc_end_o  (cyc_end),
    .cyc_bank_o (cyc_bank),
    .cyc_addr_o (cyc_addr),
    .cyc_data_o (cyc_data)
  );

  fseq_step_fsm #(
    .AW(AW), .DW(DW), .NB(NUM_BANKS),
    .U0_ADDR(U0_ADDR), .U0_DATA(U0_DATA), .U1_ADDR(U1_ADDR), .U1_DATA(U1_DATA),
    .CMD_PROG(CMD_PROG), .CMD_WR(CMD_WR), .CMD_ERS(CMD_ERS),
    .CMD_BANK(CMD_BANK), .CMD_SECT(CMD_SECT), .CMD_BLK(CMD_BLK)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_end_i   (cyc_end),
    .cyc_bank_i  (cyc_bank),
    .cyc_addr_i  (cyc_addr),
    .cyc_data_i  (cyc_data),
    .busy_i      (busy_i),
    .req_valid_o (req_valid_o),
    .req_bank_o  (req_bank_o),
    .req_op_o    (req_op),
    .req_addr_o  (req_addr_o),
    .req_data_o  (req_data_o)
  );

  assign req_op_o = req_op;

  a_r12_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o)
    else $error("request longer than one cycle");

  a_r12_legal_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_op_o >= 3'd1 && req_op_o <= 3'd5 && int'(req_bank_o) < int'(NUM_BANKS)))
    else $error("illegal request code");

  a_r3_write_ee_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_op_o == 3'd2) |-> (req_bank_o == EE_BANK))
    else $error("word write issued to a flash bank");

  a_r4_block_flash_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_op_o == 3'd4) |-> (req_bank_o != EE_BANK))
    else $error("block erase issued to the EEPROM-style bank");

endmodule

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/100ps
module flash_cmd_seq_bench;

  localparam logic [15:0] A0 = 16'h2AA5, D0 = 16'h00C3;
  localparam logic [15:0] A1 = 16'h1D5A, D1 = 16'h003C;
  localparam logic [15:0] CP = 16'h00A1, CW = 16'h00A7, CE = 16'h00E0;
  localparam logic [15:0] CB = 16'h00E1, CS = 16'h00E2, CK = 16'h00E3;

  typedef struct packed {
    logic [3:0]  rid;
    logic [1:0]  bank;
    logic [15:0] addr;
    logic [15:0] data;
    logic [2:0]  op;   // 0: no request expected
  } vec_t;

  localparam int NV = 54;
  localparam vec_t VEC [NV] = '{
    // R2 program, bank 0 and bank 1
    '{4'd2, 2'd0, A0, D0, 3'd0}, '{4'd2, 2'd0, A1, D1, 3'd0},
    '{4'd2, 2'd0, A0, CP, 3'd0}, '{4'd2, 2'd0, 16'h0123, 16'hBEEF, 3'd1},
    '{4'd2, 2'd1, A0, D0, 3'd0}, '{4'd2, 2'd1, A1, D1, 3'd0},
    '{4'd2, 2'd1, A0, CP, 3'd0}, '{4'd2, 2'd1, 16'h7FFE, 16'h0001, 3'd1},
    // R3 word write on EEPROM-style bank, then rejected on a flash bank
    '{4'd3, 2'd2, A0, D0, 3'd0}, '{4'd3, 2'd2, A1, D1, 3'd0},
    '{4'd3, 2'd2, A0, CW, 3'd0}, '{4'd3, 2'd2, 16'h001F, 16'h5A5A, 3'd2},
    '{4'd3, 2'd0, A0, D0, 3'd0}, '{4'd3, 2'd0, A1, D1, 3'd0},
    '{4'd3, 2'd0, A0, CW, 3'd0}, '{4'd3, 2'd0, 16'h0040, 16'h1234, 3'd0},
    // R4 sector erase bank 1
    '{4'd4, 2'd1, A0, D0, 3'd0}, '{4'd4, 2'd1, A1, D1, 3'd0}, '{4'd4, 2'd1, A0, CE, 3'd0},
    '{4'd4, 2'd1, A0, D0, 3'd0}, '{4'd4, 2'd1, A1, D1, 3'd0}, '{4'd4, 2'd1, 16'h0C00, CS, 3'd3},
    // R4 block erase bank 0
    '{4'd4, 2'd0, A0, D0, 3'd0}, '{4'd4, 2'd0, A1, D1, 3'd0}, '{4'd4, 2'd0, A0, CE, 3'd0},
    '{4'd4, 2'd0, A0, D0, 3'd0}, '{4'd4, 2'd0, A1, D1, 3'd0}, '{4'd4, 2'd0, 16'h8000, CK, 3'd4},
    // R4 bank erase bank 2
    '{4'd4, 2'd2, A0, D0, 3'd0}, '{4'd4, 2'd2, A1, D1, 3'd0}, '{4'd4, 2'd2, A0, CE, 3'd0},
    '{4'd4, 2'd2, A0, D0, 3'd0}, '{4'd4, 2'd2, A1, D1, 3'd0}, '{4'd4, 2'd2, A0, CB, 3'd5},
    // R4 block erase refused on bank 2
    '{4'd4, 2'd2, A0, D0, 3'd0}, '{4'd4, 2'd2, A1, D1, 3'd0}, '{4'd4, 2'd2, A0, CE, 3'd0},
    '{4'd4, 2'd2, A0, D0, 3'd0}, '{4'd4, 2'd2, A1, D1, 3'd0}, '{4'd4, 2'd2, 16'h0020, CK, 3'd0},
    // R5 wrong data at step 1
    '{4'd5, 2'd0, A0, D0, 3'd0}, '{4'd5, 2'd0, A1, 16'h00FF, 3'd0},
    '{4'd5, 2'd0, A0, CP, 3'd0}, '{4'd5, 2'd0, 16'h0010, 16'h0011, 3'd0},
    // R5 wrong address at step 4
    '{4'd5, 2'd1, A0, D0, 3'd0}, '{4'd5, 2'd1, A1, D1, 3'd0}, '{4'd5, 2'd1, A0, CE, 3'd0},
    '{4'd5, 2'd1, A0, D0, 3'd0}, '{4'd5, 2'd1, 16'h0001, D1, 3'd0}, '{4'd5, 2'd1, 16'h0C00, CS, 3'd0},
    // R5 recovery with a clean program
    '{4'd5, 2'd2, A0, D0, 3'd0}, '{4'd5, 2'd2, A1, D1, 3'd0},
    '{4'd5, 2'd2, A0, CP, 3'd0}, '{4'd5, 2'd2, 16'h0002, 16'hC0DE, 3'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_n = 1'b1, oe_n = 1'b1;
  logic [2:0]  be_n = 3'b111, busy = 3'b000;
  logic [15:0] addr = '0, data = '0;
  logic        req_valid;
  logic [1:0]  req_bank;
  logic [2:0]  req_op;
  logic [15:0] req_addr, req_data;

  int n_chk = 0, n_fail = 0;
  int req_cnt = 0, run = 0, max_run = 0;
  logic [1:0]  l_bank = '0;
  logic [2:0]  l_op = '0;
  logic [15:0] l_addr = '0, l_data = '0;

  always #2.5 clk = ~clk;

  flash_cmd_seq u_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .we_ni(we_n), .oe_ni(oe_n), .be_ni(be_n),
    .addr_i(addr), .data_i(data), .busy_i(busy),
    .req_valid_o(req_valid), .req_bank_o(req_bank), .req_op_o(req_op),
    .req_addr_o(req_addr), .req_data_o(req_data)
  );

  always @(posedge clk) begin
    if (req_valid) begin
      req_cnt <= req_cnt + 1;
      l_bank  <= req_bank;
      l_op    <= req_op;
      l_addr  <= req_addr;
      l_data  <= req_data;
      run     <= run + 1;
      if (run + 1 > max_run) max_run <= run + 1;
    end else begin
      run <= 0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // mode 0: strobe-framed, 1: enable-framed, 2: late data / early address swap, 3: OE low
  task automatic wr_cycle(input logic [1:0] b, input logic [15:0] a, input logic [15:0] d, input int mode);
    addr = a;
    data = (mode == 2) ? 16'hDEAD : d;
    if (mode == 3) oe_n = 1'b0;
    if (mode == 1) begin
      we_n = 1'b0; idle(1); be_n[b] = 1'b0;
    end else begin
      be_n[b] = 1'b0; idle(1); we_n = 1'b0;
    end
    idle(4);
    if (mode == 2) begin
      addr = 16'hFFFF;
      data = d;
      idle(2);
    end
    if (mode == 1) begin
      be_n[b] = 1'b1; idle(1); we_n = 1'b1;
    end else begin
      we_n = 1'b1; idle(1); be_n[b] = 1'b1;
    end
    oe_n = 1'b1;
    idle(5);
  endtask

  task automatic rd_cycle(input logic [1:0] b);
    be_n[b] = 1'b0; oe_n = 1'b0; addr = 16'h3333;
    idle(3);
    oe_n = 1'b1; be_n[b] = 1'b1;
    idle(2);
  endtask

  task automatic prog_seq(input logic [1:0] b, input logic [15:0] a, input logic [15:0] d, input int mode);
    wr_cycle(b, A0, D0, mode);
    wr_cycle(b, A1, D1, mode);
    wr_cycle(b, A0, CP, mode);
    wr_cycle(b, a, d, mode);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int c0;
    idle(3);
    chk("R1 valid in reset", 64'(req_valid), 64'd0);
    rst_n = 1'b1;
    idle(10);
    chk("R1 no request after reset", 64'(req_cnt), 64'd0);

    for (int i = 0; i < NV; i++) begin
      c0 = req_cnt;
      wr_cycle(VEC[i].bank, VEC[i].addr, VEC[i].data, 0);
      if (VEC[i].op != 3'd0)
        chk($sformatf("R%0d vec %0d", VEC[i].rid, i),
            {8'(req_cnt - c0), 5'd0, l_op, 6'd0, l_bank, l_addr, l_data},
            {8'd1, 5'd0, VEC[i].op, 6'd0, VEC[i].bank, VEC[i].addr, VEC[i].data});
      else
        chk($sformatf("R%0d vec %0d", VEC[i].rid, i), 64'(req_cnt - c0), 64'd0);
    end

    // R7 pause with reads of other banks between steps
    c0 = req_cnt;
    wr_cycle(2'd0, A0, D0, 0);
    rd_cycle(2'd1);
    wr_cycle(2'd0, A1, D1, 0);
    rd_cycle(2'd2);
    rd_cycle(2'd1);
    wr_cycle(2'd0, A0, CP, 0);
    rd_cycle(2'd2);
    wr_cycle(2'd0, 16'h0456, 16'h7777, 0);
    chk("R7 paused program", {8'(req_cnt - c0), 5'd0, l_op, 6'd0, l_bank, l_addr, l_data},
        {8'd1, 5'd0, 3'd1, 6'd0, 2'd0, 16'h0456, 16'h7777});

    // R8 address at open, data at close
    c0 = req_cnt;
    wr_cycle(2'd1, A0, D0, 0);
    wr_cycle(2'd1, A1, D1, 0);
    wr_cycle(2'd1, A0, CP, 0);
    wr_cycle(2'd1, 16'h0ABC, 16'h4321, 2);
    chk("R8 address sampled at open", 64'(l_addr), 64'h0ABC);
    chk("R8 data sampled at close", {8'(req_cnt - c0), 40'd0, l_data}, {8'd1, 40'd0, 16'h4321});

    // R9 enable-framed cycles
    c0 = req_cnt;
    prog_seq(2'd2, 16'h0011, 16'h9999, 1);
    chk("R9 enable-framed program", {8'(req_cnt - c0), 5'd0, l_op, 6'd0, l_bank, l_addr, l_data},
        {8'd1, 5'd0, 3'd1, 6'd0, 2'd2, 16'h0011, 16'h9999});
    c0 = req_cnt;
    wr_cycle(2'd1, A0, D0, 1);
    wr_cycle(2'd1, A1, D1, 1);
    wr_cycle(2'd1, A0, CE, 1);
    wr_cycle(2'd1, A0, D0, 1);
    wr_cycle(2'd1, A1, D1, 1);
    wr_cycle(2'd1, 16'h1400, CS, 1);
    chk("R9 enable-framed sector erase", {8'(req_cnt - c0), 5'd0, l_op, 6'd0, l_bank, l_addr, 16'd0},
        {8'd1, 5'd0, 3'd3, 6'd0, 2'd1, 16'h1400, 16'd0});

    // R10 OE-low strobe is ignored mid-sequence
    c0 = req_cnt;
    wr_cycle(2'd0, A0, D0, 0);
    wr_cycle(2'd0, A1, D1, 0);
    wr_cycle(2'd0, 16'h0BAD, 16'h0BAD, 3);
    wr_cycle(2'd0, A0, CP, 0);
    wr_cycle(2'd0, 16'h0222, 16'h0333, 0);
    chk("R10 OE-low pulse ignored", {8'(req_cnt - c0), 5'd0, l_op, 8'd0, l_addr, l_data},
        {8'd1, 5'd0, 3'd1, 8'd0, 16'h0222, 16'h0333});

    // R11 busy bank rejects a new sequence, other bank unaffected
    busy = 3'b001;
    c0 = req_cnt;
    prog_seq(2'd0, 16'h0505, 16'h0606, 0);
    chk("R11 busy bank 0 rejected", 64'(req_cnt - c0), 64'd0);
    prog_seq(2'd1, 16'h0707, 16'h0808, 0);
    chk("R11 idle bank 1 accepted", {8'(req_cnt - c0), 38'd0, l_bank, l_addr},
        {8'd1, 38'd0, 2'd1, 16'h0707});
    busy = 3'b000;

    // R6 write to another bank mid-sequence aborts
    c0 = req_cnt;
    wr_cycle(2'd0, A0, D0, 0);
    wr_cycle(2'd0, A1, D1, 0);
    wr_cycle(2'd1, A0, CP, 0);
    wr_cycle(2'd0, A0, CP, 0);
    wr_cycle(2'd0, 16'h0909, 16'h0A0A, 0);
    chk("R6 cross-bank abort", 64'(req_cnt - c0), 64'd0);

    // R12 every request lasted a single clock
    chk("R12 pulse width", 64'(max_run), 64'd1);

    idle(5);
    summary();
  end

endmodule